// File: doc/BRIEF.md
# Interlaced Display Field Freeze Controller

This block decides, at each display field time of an interlaced raster, which stored frame buffer and which of its two fields (top or bottom) the display fetches. In normal play it shows the top then the bottom field of the newest completed frame. The host can also hold the picture in one of three freeze styles: repeat the top field, alternate both fields of one frame, or repeat the bottom field. A freeze request waits for a frame boundary. A return to normal is honoured at the next field boundary.

A freeze that lasts an odd number of field times moves the frame phase against the raster parity. The block flags this inversion from its own status outputs. When automatic correction is on, the frame after a detected inversion is fetched one line down in the frame store. The mode register and the correction enable are plain input ports. The status flags are plain output ports.

Top module: `field_freeze_ctrl`

## Requirements
- R1: After reset: buffer 0, top field selected (`bot_sel_o`=0), first-field flag 1, last-field flag 0, raster-top 1, inversion 0, line offset 0.
- R2: In normal mode (`mode_i`=00) each frame is shown as two fields: top with `first_o`=1, then bottom with `last_o`=1. Each new frame takes the newest buffer posted on `new_frame_i`. A posted index at or above NUM_BUF is ignored. `first_o` and `last_o` are never both 1.
- R3: `mode_i` and `field_odd_i` are sampled only on a `field_tick_i` cycle. Between ticks no output changes.
- R4: A freeze request made while a first field is displayed has no effect at the next tick (the last field follows). It takes effect at the frame boundary after it.
- R5: `mode_i`=00 seen at any tick that is not ending a first field starts a new frame at once: newest buffer, top field, `first_o`=1.
- R6: Freeze-top (`mode_i`=01) repeats the top field of the held frame with `first_o`=`last_o`=0.
- R7: Freeze-frame (`mode_i`=10) alternates bottom and top of the held frame at each tick, starting with the field opposite to the one last shown.
- R8: Freeze-bottom (`mode_i`=11) repeats the bottom field of the held frame with `first_o`=`last_o`=0.
- R9: `raster_top_o` is the registered `field_odd_i` (1 = top raster field). `inv_o` is 1 while a first field is on a bottom raster field or a last field is on a top raster field, and 0 during held fields.
- R10: At each frame start, `line_ofs_o` becomes 1 for that frame if `auto_fix_i` is 1 and an inversion was seen since the last held field. Otherwise it becomes 0.
- R11: On an inverted sequence, a freeze-bottom held for one field realigns the phase: the next frame has `inv_o`=0 and `line_ofs_o`=0.
- R12: While frozen, `buf_o` stays constant even when new buffers are posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_tick_i | input | 1 | One-cycle strobe at each display field boundary |
| field_odd_i | input | 1 | Parity of the field starting at the tick (1 = top raster field) |
| mode_i | input | 2 | Freeze mode: 00 normal, 01 freeze top, 10 freeze frame, 11 freeze bottom |
| auto_fix_i | input | 1 | Enable automatic inversion correction |
| new_frame_i | input | 1 | Strobe: a decoded frame has completed |
| new_buf_i | input | BUF_W | Buffer index of the completed frame |
| buf_o | output | BUF_W | Frame buffer being displayed |
| bot_sel_o | output | 1 | Stored field being displayed (0 top, 1 bottom) |
| first_o | output | 1 | First field of a frame is displayed |
| last_o | output | 1 | Last field of a frame is displayed |
| raster_top_o | output | 1 | Current raster field is the top field |
| inv_o | output | 1 | Field inversion detected |
| line_ofs_o | output | 1 | Start fetch at the second line of the frame store |

## Verification
The bench makes a freeze request during a first field. A design that honours it at once would hold the picture after a single field and break the frame in two. The bench holds a freeze for three fields and then releases it. This checks that the release is taken at the very next tick, and that the resulting inversion shows on the new frame's first field. A design that latched release requests only at frame boundaries would show one extra held field. A design that compared against the wrong parity would miss the flag.

The line offset is checked with correction on and with correction off. It is also checked after a one-field bottom freeze has realigned the phase. There, an offset that still depended on a stale inversion seen before the held field would wrongly read 1. Buffer posts during a freeze and an out-of-range index expose a tracker that follows new frames too eagerly.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN      = 2'b00,
    MODE_HOLD_TOP = 2'b01,
    MODE_HOLD_FRM = 2'b10,
    MODE_HOLD_BOT = 2'b11
  } frz_mode_e;

  typedef enum logic [1:0] {
    PH_FIRST = 2'b00,
    PH_LAST  = 2'b01,
    PH_MID   = 2'b10
  } fld_phase_e;
endpackage

// File: rtl/ffc_src_track.sv
module ffc_src_track #(
  parameter int NUM_BUF = 3,
  parameter int BUF_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_frame_i,
  input  logic [BUF_W-1:0] new_buf_i,
  output logic [BUF_W-1:0] newest_o
);
  logic [BUF_W-1:0] newest_q;
  logic             idx_ok;

  // indices outside the buffer pool are dropped
  assign idx_ok = 32'(new_buf_i) < NUM_BUF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    newest_q <= '0;
    else if (new_frame_i && idx_ok) newest_q <= new_buf_i;
  end

  assign newest_o = newest_q;
endmodule

// File: rtl/ffc_field_seq.sv
module ffc_field_seq
  import ffc_pkg::*;
#(
  parameter int BUF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [BUF_W-1:0] newest_i,
  output logic [BUF_W-1:0] buf_o,
  output logic             bot_o,
  output logic             first_o,
  output logic             last_o,
  output logic             start_o,
  output logic             hold_next_o
);
  frz_mode_e        act_q, act_d, req;
  fld_phase_e       ph_q, ph_d;
  logic             bot_q, bot_d;
  logic [BUF_W-1:0] buf_q, buf_d;
  logic             start;

  assign req = frz_mode_e'(mode_i);

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bot_d = bot_q;
    buf_d = buf_q;
    start = 1'b0;
    if (tick_i) begin
      if (act_q == MODE_RUN && ph_q == PH_FIRST) begin
        // a frame is never split: first field always leads to last
        ph_d  = PH_LAST;
        bot_d = 1'b1;
      end else if (req == MODE_RUN) begin
        start = 1'b1;
        act_d = MODE_RUN;
        ph_d  = PH_FIRST;
        bot_d = 1'b0;
        buf_d = newest_i;
      end else begin
        act_d = req;
        ph_d  = PH_MID;
        unique case (req)
          MODE_HOLD_TOP: bot_d = 1'b0;
          MODE_HOLD_BOT: bot_d = 1'b1;
          default:       bot_d = ~bot_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= MODE_RUN;
      ph_q  <= PH_FIRST;
      bot_q <= 1'b0;
      buf_q <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bot_q <= bot_d;
      buf_q <= buf_d;
    end
  end

  assign buf_o       = buf_q;
  assign bot_o       = bot_q;
  assign first_o     = ph_q == PH_FIRST;
  assign last_o      = ph_q == PH_LAST;
  assign start_o     = start;
  assign hold_next_o = tick_i && ph_d == PH_MID;
endmodule

// File: rtl/ffc_inv_fix.sv
module ffc_inv_fix (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic odd_i,
  input  logic first_i,
  input  logic last_i,
  input  logic start_i,
  input  logic hold_next_i,
  input  logic auto_fix_i,
  output logic raster_top_o,
  output logic inv_o,
  output logic line_ofs_o
);
  logic raster_q, pend_q, ofs_q, inv_now;

  assign inv_now = (first_i && !raster_q) || (last_i && raster_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raster_q <= 1'b1;
      pend_q   <= 1'b0;
      ofs_q    <= 1'b0;
    end else if (tick_i) begin
      raster_q <= odd_i;
      if (start_i) begin
        ofs_q  <= auto_fix_i && (pend_q || inv_now);
        pend_q <= 1'b0;
      end else if (hold_next_i) begin
        // held fields shift the phase; earlier detection is stale
        pend_q <= 1'b0;
      end else if (inv_now) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign raster_top_o = raster_q;
  assign inv_o        = inv_now;
  assign line_ofs_o   = ofs_q;
endmodule

// File: rtl/field_freeze_ctrl.sv
module field_freeze_ctrl #(
  parameter int  NUM_BUF = 3,
  localparam int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             field_tick_i,
  input  logic             field_odd_i,
  input  logic [1:0]       mode_i,
  input  logic             auto_fix_i,
  input  logic             new_frame_i,
  input  logic [BUF_W-1:0] new_buf_i,
  output logic [BUF_W-1:0] buf_o,
  output logic             bot_sel_o,
  output logic             first_o,
  output logic             last_o,
  output logic             raster_top_o,
  output logic             inv_o,
  output logic             line_ofs_o
);
  logic [BUF_W-1:0] newest;
  logic             start, hold_next;

  ffc_src_track #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .new_frame_i (new_frame_i),
    .new_buf_i   (new_buf_i),
    .newest_o    (newest)
  );

  ffc_field_seq #(.BUF_W(BUF_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (field_tick_i),
    .mode_i      (mode_i),
    .newest_i    (newest),
    .buf_o       (buf_o),
    .bot_o       (bot_sel_o),
    .first_o     (first_o),
    .last_o      (last_o),
    .start_o     (start),
    .hold_next_o (hold_next)
  );

  ffc_inv_fix u_inv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (field_tick_i),
    .odd_i        (field_odd_i),
    .first_i      (first_o),
    .last_i       (last_o),
    .start_i      (start),
    .hold_next_i  (hold_next),
    .auto_fix_i   (auto_fix_i),
    .raster_top_o (raster_top_o),
    .inv_o        (inv_o),
    .line_ofs_o   (line_ofs_o)
  );
endmodule

// File: rtl/field_freeze_chk.sv
module field_freeze_chk #(
  parameter int BUF_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             field_tick_i,
  input logic [1:0]       mode_i,
  input logic             auto_fix_i,
  input logic [BUF_W-1:0] buf_o,
  input logic             bot_sel_o,
  input logic             first_o,
  input logic             last_o,
  input logic             raster_top_o,
  input logic             line_ofs_o
);
  AST_FIRST_LAST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(first_o && last_o)); // R2

  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_tick_i |=> $stable({buf_o, bot_sel_o, first_o, last_o, raster_top_o, line_ofs_o})); // R3

  AST_FIRST_THEN_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_tick_i && first_o |=> last_o && bot_sel_o); // R4

  AST_RELEASE_NEXT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_tick_i && mode_i == 2'b00 && !first_o |=> first_o && !bot_sel_o); // R5

  AST_HOLD_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_tick_i && mode_i == 2'b01 && !first_o |=> !bot_sel_o && !first_o && !last_o); // R6

  AST_HOLD_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_tick_i && mode_i == 2'b11 && !first_o |=> bot_sel_o && !first_o && !last_o); // R8

  AST_OFS_NEEDS_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_ofs_o) |-> first_o && $past(auto_fix_i)); // R10

  AST_HOLD_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_tick_i && mode_i != 2'b00 && !first_o |=> $stable(buf_o)); // R12
endmodule

bind field_freeze_ctrl field_freeze_chk #(.BUF_W(BUF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .field_tick_i (field_tick_i),
  .mode_i       (mode_i),
  .auto_fix_i   (auto_fix_i),
  .buf_o        (buf_o),
  .bot_sel_o    (bot_sel_o),
  .first_o      (first_o),
  .last_o       (last_o),
  .raster_top_o (raster_top_o),
  .line_ofs_o   (line_ofs_o)
);

// File: tb/field_freeze_ctrl_tb.sv
module field_freeze_ctrl_tb;
  localparam int NUM_BUF = 3;
  localparam int BUF_W   = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             field_tick_i = 1'b0;
  logic             field_odd_i = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic             auto_fix_i = 1'b0;
  logic             new_frame_i = 1'b0;
  logic [BUF_W-1:0] new_buf_i = '0;
  logic [BUF_W-1:0] buf_o;
  logic             bot_sel_o, first_o, last_o, raster_top_o, inv_o, line_ofs_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  field_freeze_ctrl #(.NUM_BUF(NUM_BUF)) u_dut (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // buf, bot, first, last, raster, inv, ofs
  task automatic chk_all(input string req, input int b, input int bot, input int f,
                         input int l, input int r, input int inv, input int ofs);
    chk({req, " buf"}, int'(buf_o), b);
    chk({req, " bot"}, int'(bot_sel_o), bot);
    chk({req, " first"}, int'(first_o), f);
    chk({req, " last"}, int'(last_o), l);
    chk({req, " raster"}, int'(raster_top_o), r);
    chk({req, " inv"}, int'(inv_o), inv);
    chk({req, " ofs"}, int'(line_ofs_o), ofs);
  endtask

  task automatic tick(input logic par);
    @(negedge clk_i);
    field_tick_i = 1'b1;
    field_odd_i  = par;
    @(negedge clk_i);
    field_tick_i = 1'b0;
  endtask

  task automatic post(input logic [BUF_W-1:0] b);
    @(negedge clk_i);
    new_frame_i = 1'b1;
    new_buf_i   = b;
    @(negedge clk_i);
    new_frame_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_all("R1 reset", 0, 0, 1, 0, 1, 0, 0);
  endtask

  task automatic t_normal;
    post(2'd1);
    tick(1'b0);
    chk_all("R2 last field", 0, 1, 0, 1, 0, 0, 0);
    tick(1'b1);
    chk_all("R2 new frame", 1, 0, 1, 0, 1, 0, 0);
    post(2'd3);
    post(2'd2);
    tick(1'b0);
    chk_all("R2 second last", 1, 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_mid_field;
    @(negedge clk_i);
    mode_i = 2'b01;
    repeat (5) @(negedge clk_i);
    chk_all("R3 no tick no change", 1, 1, 0, 1, 0, 0, 0);
    mode_i = 2'b00;
  endtask

  task automatic t_late_req;
    tick(1'b1);
    chk_all("R2 out-of-range index ignored", 2, 0, 1, 0, 1, 0, 0);
    mode_i = 2'b01;
    tick(1'b0);
    chk_all("R4 request in first field deferred", 2, 1, 0, 1, 0, 0, 0);
    tick(1'b1);
    chk_all("R6 hold top", 2, 0, 0, 0, 1, 0, 0);
    post(2'd0);
    tick(1'b0);
    chk_all("R12 buffer held", 2, 0, 0, 0, 0, 0, 0);
    tick(1'b1);
    chk_all("R6 hold top again", 2, 0, 0, 0, 1, 0, 0);
    mode_i = 2'b00;
    tick(1'b0);
    chk_all("R5 R9 release and inversion", 0, 0, 1, 0, 0, 1, 0);
    tick(1'b1);
    chk_all("R9 inverted last field", 0, 1, 0, 1, 1, 1, 0);
    auto_fix_i = 1'b1;
    post(2'd1);
    tick(1'b0);
    chk_all("R10 offset applied", 1, 0, 1, 0, 0, 1, 1);
    tick(1'b1);
    chk("R10 offset kept in frame", int'(line_ofs_o), 1);
    auto_fix_i = 1'b0;
    tick(1'b0);
    chk_all("R10 no offset when disabled", 1, 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_fix;
    tick(1'b1);
    chk("R9 inverted before fix", int'(inv_o), 1);
    mode_i = 2'b11;
    tick(1'b0);
    chk_all("R8 one-field bottom hold", 1, 1, 0, 0, 0, 0, 0);
    mode_i = 2'b00;
    auto_fix_i = 1'b1;
    tick(1'b1);
    chk_all("R11 phase realigned", 1, 0, 1, 0, 1, 0, 0);
    tick(1'b0);
    chk_all("R11 last field aligned", 1, 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_freeze_frame;
    mode_i = 2'b10;
    tick(1'b1);
    chk_all("R7 alternate top", 1, 0, 0, 0, 1, 0, 0);
    post(2'd2);
    tick(1'b0);
    chk_all("R7 alternate bottom", 1, 1, 0, 0, 0, 0, 0);
    tick(1'b1);
    chk_all("R7 alternate top again", 1, 0, 0, 0, 1, 0, 0);
    mode_i = 2'b00;
    tick(1'b0);
    chk_all("R5 R10 release, stale cleared", 2, 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_freeze_last;
    tick(1'b1);
    chk("R2 last after first", int'(last_o), 1);
    mode_i = 2'b11;
    tick(1'b0);
    chk_all("R8 hold bottom", 2, 1, 0, 0, 0, 0, 0);
    tick(1'b1);
    chk_all("R8 hold bottom 2", 2, 1, 0, 0, 1, 0, 0);
    tick(1'b0);
    chk_all("R8 hold bottom 3", 2, 1, 0, 0, 0, 0, 0);
    mode_i = 2'b00;
    tick(1'b1);
    chk_all("R5 R9 odd hold realigns", 2, 0, 1, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_mid_field();
    t_late_req();
    t_fix();
    t_freeze_frame();
    t_freeze_last();
    repeat (4) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule